// File: doc/BRIEF.md
# Power Management Event and Timer Register Block

This block holds the power management event registers of a system controller. A free-running counter advances at a fixed timer rate. The timer rate is derived from the system clock by a fractional accumulator, so the long-term average rate is exact. An event status word, an enable word and a control word sit on a small register bus. Word reads and writes go to status, enable and control. A 32-bit read returns the counter.

When an enabled event is pending, the block holds a level system control interrupt (SCI) high. Firmware acknowledges events by writing ones to the status word. Writing the control word with the sleep-enable bit set fires a one-cycle power-off request or a suspend request, chosen by a three-bit sleep-type field. A separate byte port carries mode commands that switch the SCI-enable bit in the control word on or off. A companion byte register on that port is plain storage. A power button pulse input feeds the button event.

Top module: `pm_event_regs`

## Requirements
- R1: While reset is held, status, enable, control, counter, both mode-port bytes, `sciLevel`, `powerOffReq` and `suspendReq` are all zero.
- R2: The counter is `TMR_W` bits wide and advances by exactly `TICK_HZ` counts (modulo 2^`TMR_W`) every `SYS_CLK_HZ` clock cycles. It never steps by more than one count per cycle. A read at offset 0x08 returns the counter in the low `TMR_W` bits, with the upper bits zero.
- R3: Status bit 0 sets whenever counter bit `TMR_W`-1 changes value. Once set, it stays set until it is cleared.
- R4: A write to status at offset 0x00 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: Enable at offset 0x02 stores all 16 bits. Control at offset 0x04 stores every bit except bit 13, which always reads 0. Reads at any offset other than 0x00, 0x02, 0x04 and 0x08 return zero, and writes to those offsets change no register.
- R6: `sciLevel` is high exactly when at least one of bits 0, 5, 8 and 10 is set in both status and enable.
- R7: A control write with bit 13 set and bits 12:10 equal to 0 raises `powerOffReq` for exactly one cycle. That pulse starts in the cycle after the write edge.
- R8: A control write with bit 13 set and bits 12:10 equal to 1 raises `suspendReq` for one cycle and sets status bits 15 and 8. Any other sleep type raises no request. The two requests are never high together.
- R9: On the mode port, a byte written at address 0 reads back at address 0. Writing 0xF1 sets control bit 0, writing 0xF0 clears it, and any other value leaves it unchanged. A byte written at address 1 reads back at address 1 and does not touch control.
- R10: A `pwrBtnEvt` pulse sets status bit 8 only when enable bit 8 is set. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte offset within the register window |
| busWrite | input | 1 | Write strobe for the register window |
| busWdata | input | 16 | Write data for status, enable and control |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| modeAddr | input | 1 | Mode port select: 0 command byte, 1 companion byte |
| modeWrite | input | 1 | Write strobe for the mode port |
| modeWdata | input | 8 | Mode port write data |
| modeRdata | output | 8 | Mode port read data for `modeAddr` |
| pwrBtnEvt | input | 1 | One-cycle power button event |
| sciLevel | output | 1 | Level system control interrupt |
| powerOffReq | output | 1 | One-cycle power-off request |
| suspendReq | output | 1 | One-cycle suspend request |

## Verification
The bench builds the block with `TMR_W` = 6, `SYS_CLK_HZ` = 4 and `TICK_HZ` = 3. The accumulator then ticks three cycles out of four, so every counter delta is an exact multiple that can be predicted from the cycle count. A top-bit change happens about every 43 cycles, and the counter wraps about every 85 cycles. With this small setup, overflow setting, re-setting after a clear, and counter wrap all fall inside short waits. The same setup also allows full sweeps of all 256 mode bytes, all eight sleep types, every enable bit against the SCI, and every unused offset.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  // register offsets inside the 64-byte window
  localparam logic [5:0] OFS_STS = 6'h00;
  localparam logic [5:0] OFS_EN  = 6'h02;
  localparam logic [5:0] OFS_CTL = 6'h04;
  localparam logic [5:0] OFS_TMR = 6'h08;

  // bit positions with behaviour attached
  localparam int BIT_TMR_OVF = 0;
  localparam int BIT_BTN     = 8;
  localparam int BIT_RESUME  = 15;
  localparam int BIT_SLP_GO  = 13;
  localparam int SLP_TYP_LO  = 10;

  localparam logic [15:0] SCI_SRC_MASK = 16'h0521; // bits 10, 8, 5, 0

  localparam logic [7:0] MODE_ON  = 8'hF1;
  localparam logic [7:0] MODE_OFF = 8'hF0;

  localparam logic [2:0] SLP_OFF  = 3'd0;
  localparam logic [2:0] SLP_SUSP = 3'd1;

  typedef struct packed {
    logic        wrSts;
    logic        wrEn;
    logic        wrCtl;
    logic        goOff;
    logic        goSusp;
    logic        sciSet;
    logic        sciClr;
    logic        wrCmd;
    logic        wrAux;
    logic [15:0] data;
    logic [7:0]  modeData;
  } ctlStrobe_t;

endpackage

// File: rtl/pm_evt_timer.sv
module pm_evt_timer #(
  parameter int unsigned SYS_CLK_HZ = 125_000_000,
  parameter int unsigned TICK_HZ    = 3_579_545,
  parameter int unsigned TMR_W      = 24
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [TMR_W-1:0] count,
  output logic             ovf
);
  localparam int ACC_W = $clog2(SYS_CLK_HZ + TICK_HZ + 1) + 1;
  localparam logic [ACC_W-1:0] SYS_V  = ACC_W'(SYS_CLK_HZ);
  localparam logic [ACC_W-1:0] TICK_V = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] accQ, accSum, accD;
  logic [TMR_W-1:0] countQ, countNext;
  logic             tick;

  always_comb begin
    accSum    = accQ + TICK_V;
    tick      = (accSum >= SYS_V);
    accD      = tick ? (accSum - SYS_V) : accSum;
    countNext = countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      countQ <= '0;
    end else begin
      accQ <= accD;
      if (tick) countQ <= countNext;
    end
  end

  assign count = countQ;
  assign ovf   = tick && (countNext[TMR_W-1] != countQ[TMR_W-1]);
endmodule

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
(
  input  logic       [5:0]  busAddr,
  input  logic              busWrite,
  input  logic       [15:0] busWdata,
  input  logic              modeAddr,
  input  logic              modeWrite,
  input  logic       [7:0]  modeWdata,
  output ctlStrobe_t        strobe
);
  logic [2:0] slpType;
  logic       slpGo;

  always_comb begin
    slpType = busWdata[SLP_TYP_LO +: 3];
    slpGo   = busWdata[BIT_SLP_GO];

    strobe          = '0;
    strobe.data     = busWdata;
    strobe.modeData = modeWdata;

    if (busWrite) begin
      unique case (busAddr)
        OFS_STS: strobe.wrSts = 1'b1;
        OFS_EN:  strobe.wrEn  = 1'b1;
        OFS_CTL: begin
          strobe.wrCtl  = 1'b1;
          strobe.goOff  = slpGo && (slpType == SLP_OFF);
          strobe.goSusp = slpGo && (slpType == SLP_SUSP);
        end
        default: ;
      endcase
    end

    if (modeWrite) begin
      if (!modeAddr) begin
        strobe.wrCmd  = 1'b1;
        strobe.sciSet = (modeWdata == MODE_ON);
        strobe.sciClr = (modeWdata == MODE_OFF);
      end else begin
        strobe.wrAux = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pm_evt_datapath.sv
module pm_evt_datapath
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              tmrOvf,
  input  logic [TMR_W-1:0]  tmrCount,
  input  logic              pwrBtnEvt,
  input  logic [5:0]        busAddr,
  input  logic              modeAddr,
  output logic [31:0]       busRdata,
  output logic [7:0]        modeRdata,
  output logic [15:0]       stsQ,
  output logic [15:0]       enQ,
  output logic [15:0]       ctlQ,
  output logic              sciLevel,
  output logic              powerOffReq,
  output logic              suspendReq
);
  logic [15:0] stsD, ctlD, stsSet, stsClr;
  logic [7:0]  cmdQ, auxQ;
  logic        offQ, suspQ;

  always_comb begin
    stsSet = '0;
    stsSet[BIT_TMR_OVF] = tmrOvf;
    stsSet[BIT_BTN]     = (pwrBtnEvt && enQ[BIT_BTN]) || strobe.goSusp;
    stsSet[BIT_RESUME]  = strobe.goSusp;
    stsClr = strobe.wrSts ? strobe.data : 16'h0000;
    stsD   = (stsQ & ~stsClr) | stsSet;

    ctlD = ctlQ;
    if (strobe.wrCtl) begin
      ctlD = strobe.data;
      ctlD[BIT_SLP_GO] = 1'b0;
    end
    if (strobe.sciSet) ctlD[0] = 1'b1;
    if (strobe.sciClr) ctlD[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ  <= '0;
      enQ   <= '0;
      ctlQ  <= '0;
      cmdQ  <= '0;
      auxQ  <= '0;
      offQ  <= 1'b0;
      suspQ <= 1'b0;
    end else begin
      stsQ  <= stsD;
      ctlQ  <= ctlD;
      offQ  <= strobe.goOff;
      suspQ <= strobe.goSusp;
      if (strobe.wrEn)  enQ  <= strobe.data;
      if (strobe.wrCmd) cmdQ <= strobe.modeData;
      if (strobe.wrAux) auxQ <= strobe.modeData;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_STS: busRdata = {16'h0000, stsQ};
      OFS_EN:  busRdata = {16'h0000, enQ};
      OFS_CTL: busRdata = {16'h0000, ctlQ};
      OFS_TMR: busRdata = 32'(tmrCount);
      default: busRdata = 32'h0;
    endcase
  end

  assign modeRdata   = modeAddr ? auxQ : cmdQ;
  assign sciLevel    = |(stsQ & enQ & SCI_SRC_MASK);
  assign powerOffReq = offQ;
  assign suspendReq  = suspQ;
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_evt_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 125_000_000,
  parameter int unsigned TICK_HZ    = 3_579_545,
  parameter int unsigned TMR_W      = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWrite,
  input  logic [15:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        modeAddr,
  input  logic        modeWrite,
  input  logic [7:0]  modeWdata,
  output logic [7:0]  modeRdata,
  input  logic        pwrBtnEvt,
  output logic        sciLevel,
  output logic        powerOffReq,
  output logic        suspendReq
);
  ctlStrobe_t       strobe;
  logic [TMR_W-1:0] tmrCount;
  logic             tmrOvf;
  logic [15:0]      stsQ, enQ, ctlQ;

  pm_evt_timer #(
    .SYS_CLK_HZ(SYS_CLK_HZ), .TICK_HZ(TICK_HZ), .TMR_W(TMR_W)
  ) u_tmr (
    .clk(clk), .rstN(rstN), .count(tmrCount), .ovf(tmrOvf)
  );

  pm_evt_ctrl u_ctrl (
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .modeAddr(modeAddr), .modeWrite(modeWrite), .modeWdata(modeWdata),
    .strobe(strobe)
  );

  pm_evt_datapath #(.TMR_W(TMR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tmrOvf(tmrOvf), .tmrCount(tmrCount), .pwrBtnEvt(pwrBtnEvt),
    .busAddr(busAddr), .modeAddr(modeAddr),
    .busRdata(busRdata), .modeRdata(modeRdata),
    .stsQ(stsQ), .enQ(enQ), .ctlQ(ctlQ),
    .sciLevel(sciLevel), .powerOffReq(powerOffReq), .suspendReq(suspendReq)
  );
endmodule

// File: rtl/pm_evt_checker.sv
module pm_evt_checker #(
  parameter int unsigned TMR_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic [5:0]       busAddr,
  input logic             busWrite,
  input logic [15:0]      busWdata,
  input logic             modeAddr,
  input logic             modeWrite,
  input logic [7:0]       modeWdata,
  input logic             pwrBtnEvt,
  input logic             powerOffReq,
  input logic             suspendReq,
  input logic [15:0]      stsQ,
  input logic [15:0]      enQ,
  input logic [15:0]      ctlQ,
  input logic [TMR_W-1:0] tmrCount,
  input logic             tmrOvf
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tmrCount == $past(tmrCount)) || (tmrCount == TMR_W'($past(tmrCount) + 1'b1)));

  assert_ovf_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |=> stsQ[0]);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 6'h00 && busWdata[0] && !tmrOvf) |=> !stsQ[0]);

  assert_off_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> !powerOffReq);

  assert_req_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(powerOffReq && suspendReq));

  assert_mode_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrite && !modeAddr && modeWdata == 8'hF1) |=> ctlQ[0]);

  assert_btn_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pwrBtnEvt && !enQ[8] && !stsQ[8] && !(busWrite && busAddr == 6'h04 && busWdata[13]))
      |=> !stsQ[8]);
endmodule

bind pm_event_regs pm_evt_checker #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .busWdata(busWdata), .modeAddr(modeAddr), .modeWrite(modeWrite),
  .modeWdata(modeWdata), .pwrBtnEvt(pwrBtnEvt), .powerOffReq(powerOffReq),
  .suspendReq(suspendReq), .stsQ(stsQ), .enQ(enQ), .ctlQ(ctlQ),
  .tmrCount(tmrCount), .tmrOvf(tmrOvf)
);

// File: tb/sim_pm_event_regs.sv
module sim_pm_event_regs;
  localparam int W = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [15:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        modeAddr = 1'b0;
  logic        modeWrite = 1'b0;
  logic [7:0]  modeWdata = '0;
  logic [7:0]  modeRdata;
  logic        pwrBtnEvt = 1'b0;
  logic        sciLevel, powerOffReq, suspendReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pm_event_regs #(.SYS_CLK_HZ(4), .TICK_HZ(3), .TMR_W(W)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .modeAddr(modeAddr),
    .modeWrite(modeWrite), .modeWdata(modeWdata), .modeRdata(modeRdata),
    .pwrBtnEvt(pwrBtnEvt), .sciLevel(sciLevel), .powerOffReq(powerOffReq),
    .suspendReq(suspendReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic modeWr(input logic a, input logic [7:0] d);
    @(negedge clk);
    modeAddr = a; modeWdata = d; modeWrite = 1'b1;
    @(negedge clk);
    modeWrite = 1'b0;
  endtask

  task automatic modeRd(input logic a, output logic [7:0] d);
    modeAddr = a;
    #1 d = modeRdata;
  endtask

  task automatic btnPulse();
    @(negedge clk);
    pwrBtnEvt = 1'b1;
    @(negedge clk);
    pwrBtnEvt = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd, t1;
    logic [7:0]  mb;
    logic        ctl0;
    logic [15:0] enSave, ctlSave;

    // R1 reset state, observed while reset is held
    repeat (3) @(negedge clk);
    busAddr = 6'h00; #1 chk("R1 status", busRdata, 0);
    busAddr = 6'h02; #1 chk("R1 enable", busRdata, 0);
    busAddr = 6'h04; #1 chk("R1 control", busRdata, 0);
    busAddr = 6'h08; #1 chk("R1 timer", busRdata, 0);
    modeRd(1'b0, mb); chk("R1 cmd byte", 32'(mb), 0);
    modeRd(1'b1, mb); chk("R1 aux byte", 32'(mb), 0);
    chk("R1 outputs", {29'd0, sciLevel, powerOffReq, suspendReq}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 rate: 3 counts per 4 cycles, modulo 64
    begin
      int spans [3] = '{4, 40, 100};
      foreach (spans[i]) begin
        busRd(6'h08, t1);
        repeat (spans[i]) @(negedge clk);
        #1 rd = busRdata;
        chk("R2 timer delta", rd, (t1 + 32'(spans[i] * 3 / 4)) % 64);
        chk("R2 upper zero", {26'd0, rd[31:W]}, 0);
      end
    end

    // R5 enable and control storage, bit 13 never stored
    busWr(6'h02, 16'hA5C3);
    busRd(6'h02, rd); chk("R5 enable readback", rd, 32'h0000A5C3);
    busWr(6'h04, 16'h1ABE);
    busRd(6'h04, rd); chk("R5 control readback", rd, 32'h00001ABE);
    busWr(6'h04, 16'h3FFF);
    chk("R5 type7 no request", {30'd0, powerOffReq, suspendReq}, 0);
    busRd(6'h04, rd); chk("R5 bit13 not stored", rd, 32'h00001FFF);

    // R5 unused offsets: read zero, writes change nothing
    enSave = 16'hA5C3; ctlSave = 16'h1FFF;
    for (int a = 0; a < 64; a++) begin
      if (a == 0 || a == 2 || a == 4) continue;
      busWr(6'(a), 16'hFFFF);
      if (a != 8) begin
        busRd(6'(a), rd);
        chk("R5 unused reads zero", rd, 0);
      end
    end
    busRd(6'h02, rd); chk("R5 enable untouched", rd, 32'(enSave));
    busRd(6'h04, rd); chk("R5 control untouched", rd, 32'(ctlSave));
    busRd(6'h00, rd); chk("R5 status untouched", rd & 32'hFFFE, 0);

    // R7 power-off pulse
    busWr(6'h04, 16'h2000);
    chk("R7 off pulse high", {30'd0, powerOffReq, suspendReq}, 32'h2);
    @(negedge clk);
    chk("R7 off pulse one cycle", {31'd0, powerOffReq}, 0);

    // R8 sleep type sweep
    for (int t = 1; t < 8; t++) begin
      busWr(6'h04, 16'h2000 | 16'(t << 10));
      chk("R8 suspend req", {31'd0, suspendReq}, (t == 1) ? 1 : 0);
      chk("R8 no off req", {31'd0, powerOffReq}, 0);
      if (t == 1) begin
        busRd(6'h00, rd);
        chk("R8 status 15 and 8", rd & 32'h8100, 32'h8100);
        chk("R8 suspend one cycle", {31'd0, suspendReq}, 0);
      end
    end

    // R4 write-one-to-clear
    busWr(6'h00, 16'h0100);
    busRd(6'h00, rd); chk("R4 clear bit8 only", rd & 32'hFFFE, 32'h8000);
    busWr(6'h00, 16'h8000);
    busRd(6'h00, rd); chk("R4 clear bit15", rd & 32'hFFFE, 0);

    // R3 overflow on top-bit change
    do busRd(6'h08, rd); while (rd[4:0] != 5'd2);
    busWr(6'h00, 16'h0001);
    #1 chk("R3 cleared", busRdata & 32'h1, 0);
    repeat (12) @(negedge clk);
    busRd(6'h00, rd); chk("R3 not before boundary", rd & 32'h1, 0);
    repeat (40) @(negedge clk);
    busRd(6'h00, rd); chk("R3 set after boundary", rd & 32'h1, 1);

    // R10 button gating
    busWr(6'h02, 16'h0000);
    btnPulse();
    busRd(6'h00, rd); chk("R10 gated off", rd & 32'h0100, 0);
    busWr(6'h02, 16'h0100);
    btnPulse();
    busRd(6'h00, rd); chk("R10 gated on", rd & 32'h0100, 32'h0100);
    chk("R6 sci from button", {31'd0, sciLevel}, 1);

    // R6 SCI sweep over each enable bit with status bits 0, 8, 15 set
    busWr(6'h04, 16'h2400);
    repeat (50) @(negedge clk);
    busRd(6'h00, rd); chk("R6 setup status", rd & 32'h8101, 32'h8101);
    for (int b = 0; b < 16; b++) begin
      busWr(6'h02, 16'(1 << b));
      chk("R6 sci per enable bit", {31'd0, sciLevel}, (b == 0 || b == 8) ? 1 : 0);
    end

    // R9 mode byte sweep
    busRd(6'h04, rd); ctl0 = rd[0];
    chk("R9 start control bit0", {31'd0, ctl0}, 0);
    for (int v = 0; v < 256; v++) begin
      modeWr(1'b0, 8'(v));
      if (v == 8'hF1) ctl0 = 1'b1;
      else if (v == 8'hF0) ctl0 = 1'b0;
      busRd(6'h04, rd);
      chk("R9 control bit0", {31'd0, rd[0]}, {31'd0, ctl0});
      modeRd(1'b0, mb);
      chk("R9 cmd readback", 32'(mb), v);
    end
    modeWr(1'b0, 8'hF1);
    modeWr(1'b1, 8'hF0);
    modeRd(1'b1, mb); chk("R9 aux readback", 32'(mb), 32'hF0);
    modeRd(1'b0, mb); chk("R9 cmd kept", 32'(mb), 32'hF1);
    busRd(6'h04, rd); chk("R9 aux leaves control", rd & 32'h1, 1);

    done = 1'b1;
    finishRun();
  end
endmodule